// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves transmit data for a network controller. Software builds a linear ring of 32-byte descriptors in memory, hands each one to hardware by setting its ownership bit, and then raises a poll request. The walker reads each owned descriptor through a word-wide memory read port. It streams the referenced buffer out one byte at a time on a valid/ready interface, flagging the final byte of a frame. It then returns the descriptor to software by writing its control word back with the ownership bit cleared. The walk continues until the walker meets a descriptor it does not own.

The next descriptor is either the one 32 bytes further on, or the ring base when the descriptor asks for a wrap. The ring base and the current pointer are both set from a base-load strobe while the walker is idle. A poll that arrives during a walk is remembered, and it starts a fresh walk once the current one has stopped. Size fields that exceed the supported limits are reported on a one-cycle error pulse, and the walker does not stop for them.

Top module: `txring_walker`

## Requirements
- R1: While reset is held, and in the cycle after reset is released, busy, tx_valid, tx_last, mem_rd_en, mem_wr_en, frame_done and seg_err are all low.
- R2: A poll request starts a walk that reads the control word at the current pointer. If bit 31 (owned by hardware) of that word is clear, the walker returns to idle with no data beat and no write. While idle it makes no memory access and offers no data.
- R3: Descriptor layout, as byte offsets from the descriptor address: the control word is at +0. The size word is at +4, with the buffer-1 length in bits 11:0 and the buffer-2 length in bits 27:16. The buffer address is at +8. The segment length is the sum of the two lengths. The bytes are read from the buffer address onward, at any byte alignment, and byte k of a 32-bit word is bits 8k+7:8k. All memory reads are word aligned.
- R4: Once tx_valid is high, tx_data and tx_last hold steady until tx_ready is seen high. No memory read is issued while a byte is on offer.
- R5: tx_last is high only on the final byte of a segment whose control bit 29 (end of frame) is set. frame_done pulses for one cycle, in the cycle after the write-back of such a descriptor. A zero-length segment sends no byte.
- R6: After its data, each owned descriptor gets exactly one write, to its own address, of its control word with only bit 31 cleared.
- R7: If control bit 21 is set, the next descriptor address is the ring base. Otherwise it is the current address plus 32. The walk ends at the first descriptor that is not owned.
- R8: seg_err pulses once for a descriptor whose buffer-1 length exceeds 2048 or whose buffer-2 length is nonzero. A length of exactly 2048 is accepted. Processing carries on in either case.
- R9: A poll request that arrives while busy is latched. After the walk stops, a new walk starts and re-reads the control word at the stop address.
- R10: While idle, base_load sets both the ring base and the current pointer to base_addr. While busy, base_load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_req | input | 1 | Poll demand pulse |
| base_load | input | 1 | Load ring base and current pointer |
| base_addr | input | AW | Ring base byte address |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Word-aligned read byte address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Descriptor write-back strobe |
| mem_wr_addr | output | AW | Write-back byte address |
| mem_wr_data | output | 32 | Write-back control word |
| tx_valid | output | 1 | Frame byte on offer |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| frame_done | output | 1 | Frame completed pulse |
| seg_err | output | 1 | Size field error pulse |
| busy | output | 1 | Walk in progress |

## Verification
Two of the block's functions can fall in the same cycle. A poll request can arrive while the walker is still busy with a walk, and the stop of that walk can then take effect together with the latched restart. This is provoked by pulsing poll_req in the middle of a frame whose ring ends at a non-owned descriptor. It is judged by counting the control-word reads at the stop address, which must come to exactly two. The bench also pulses base_load in the middle of a walk, then checks through the wrap descriptor and the final stop address that the old base stayed in force.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int unsigned OWN_BIT     = 31;
  localparam int unsigned EOF_BIT     = 29;
  localparam int unsigned WRAP_BIT    = 21;
  localparam int unsigned DESC_STRIDE = 32;
  localparam int unsigned WORD_BYTES  = 4;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_FRD,   // issue descriptor field read
    WK_FWT,   // capture descriptor field
    WK_BRD,   // issue buffer word read
    WK_BWT,   // load byte into output register
    WK_HOLD,  // wait for sink
    WK_WB     // write descriptor back, advance pointer
  } walk_st_t;
endpackage

// File: rtl/txr_seg_len.sv
module txr_seg_len #(
  parameter int LENW   = 12,
  parameter int B1_MAX = 2048
) (
  input  logic [2*LENW-1:0] size_pair,
  output logic [LENW:0]     seg_len,
  output logic              size_bad
);
  logic [LENW-1:0] len_a;
  logic [LENW-1:0] len_b;

  assign len_a    = size_pair[LENW-1:0];
  assign len_b    = size_pair[2*LENW-1:LENW];
  assign seg_len  = {1'b0, len_a} + {1'b0, len_b};
  assign size_bad = ({1'b0, len_a} > (LENW+1)'(B1_MAX)) || (len_b != '0);
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_we,
  input  logic [AW-1:0] base_in,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] cur
);
  localparam logic [AW-1:0] STEP = AW'(txr_pkg::DESC_STRIDE);

  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur    <= '0;
    end else if (base_we) begin
      base_q <= base_in;
      cur    <= base_in;
    end else if (advance) begin
      cur <= wrap ? base_q : cur + STEP;
    end
  end
endmodule

// File: rtl/txr_byte_out.sv
module txr_byte_out #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [BW-1:0] din,
  input  logic          last_in,
  input  logic          ready,
  output logic          valid,
  output logic [BW-1:0] data,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
      last  <= last_in;
    end else if (ready) begin
      valid <= 1'b0;
      last  <= 1'b0;
    end
  end
endmodule

// File: rtl/txring_walker.sv
module txring_walker #(
  parameter int AW   = 16,
  parameter int LENW = 12,
  parameter int B1_MAX = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          poll_req,
  input  logic          base_load,
  input  logic [AW-1:0] base_addr,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [31:0]   mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          frame_done,
  output logic          seg_err,
  output logic          busy
);
  import txr_pkg::*;

  localparam int CW    = LENW + 1;
  localparam int LANES = WORD_BYTES;

  walk_st_t        st;
  logic [1:0]      fidx;
  logic [31:0]     ctl_q;
  logic [2*LENW-1:0] size_q;
  logic [AW-1:0]   buf_q;
  logic [CW-1:0]   cnt;
  logic            pend;
  logic            done_q;
  logic            err_q;

  logic [AW-1:0]   ptr;
  logic [CW-1:0]   seg_len;
  logic            size_bad;
  logic [AW-1:0]   byte_addr;
  logic            last_byte;
  logic [7:0]      lane_byte [LANES];
  logic            want_walk;
  logic            base_we;
  logic            taken;

  txr_seg_len #(.LENW(LENW), .B1_MAX(B1_MAX)) u_len (
    .size_pair (size_q),
    .seg_len   (seg_len),
    .size_bad  (size_bad)
  );

  txr_ring_ptr #(.AW(AW)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .base_we (base_we),
    .base_in (base_addr),
    .advance (st == WK_WB),
    .wrap    (ctl_q[WRAP_BIT]),
    .cur     (ptr)
  );

  txr_byte_out #(.BW(8)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (st == WK_BWT),
    .din     (lane_byte[byte_addr[1:0]]),
    .last_in (last_byte && ctl_q[EOF_BIT]),
    .ready   (tx_ready),
    .valid   (tx_valid),
    .data    (tx_data),
    .last    (tx_last)
  );

  // Byte lanes of the returned memory word, little-endian.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = mem_rd_data[8*g +: 8];
  end

  assign byte_addr = buf_q + AW'(cnt);
  assign last_byte = (cnt == seg_len - CW'(1));
  assign want_walk = pend | poll_req;
  assign base_we   = (st == WK_IDLE) && base_load;
  assign taken     = tx_valid && tx_ready;

  assign mem_rd_en   = (st == WK_FRD) || (st == WK_BRD);
  assign mem_rd_addr = (st == WK_FRD) ? ptr + AW'({fidx, 2'b00})
                                      : {byte_addr[AW-1:2], 2'b00};
  assign mem_wr_en   = (st == WK_WB);
  assign mem_wr_addr = ptr;
  assign mem_wr_data = ctl_q & ~(32'd1 << OWN_BIT);
  assign busy        = (st != WK_IDLE);
  assign frame_done  = done_q;
  assign seg_err     = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= WK_IDLE;
      fidx   <= '0;
      ctl_q  <= '0;
      size_q <= '0;
      buf_q  <= '0;
      cnt    <= '0;
      pend   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (st != WK_IDLE && poll_req) pend <= 1'b1;
      case (st)
        WK_IDLE: begin
          if (base_load) begin
            pend <= want_walk;
          end else if (want_walk) begin
            pend <= 1'b0;
            fidx <= '0;
            st   <= WK_FRD;
          end
        end
        WK_FRD: st <= WK_FWT;
        WK_FWT: begin
          case (fidx)
            2'd0: begin
              ctl_q <= mem_rd_data;
              if (!mem_rd_data[OWN_BIT]) begin
                st <= WK_IDLE;
              end else begin
                fidx <= 2'd1;
                st   <= WK_FRD;
              end
            end
            2'd1: begin
              size_q <= {mem_rd_data[16 +: LENW], mem_rd_data[LENW-1:0]};
              fidx   <= 2'd2;
              st     <= WK_FRD;
            end
            default: begin
              buf_q <= mem_rd_data[AW-1:0];
              cnt   <= '0;
              err_q <= size_bad;
              st    <= (seg_len == '0) ? WK_WB : WK_BRD;
            end
          endcase
        end
        WK_BRD: st <= WK_BWT;
        WK_BWT: st <= WK_HOLD;
        WK_HOLD: begin
          if (taken) begin
            if (last_byte) begin
              st <= WK_WB;
            end else begin
              cnt <= cnt + CW'(1);
              st  <= WK_BRD;
            end
          end
        end
        WK_WB: begin
          done_q <= ctl_q[EOF_BIT];
          fidx   <= '0;
          st     <= WK_FRD;
        end
        default: st <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txring_walker_chk.sv
module txring_walker_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       mem_rd_en,
  input logic [1:0] rd_lsb,
  input logic       mem_wr_en,
  input logic       wr_own,
  input logic       wr_eof,
  input logic       frame_done
);
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R4
  AST_NO_READ_ON_OFFER: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !mem_rd_en); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd_en && !mem_wr_en && !tx_valid); // R2
  AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> rd_lsb == 2'b00); // R3
  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !wr_own); // R6
  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(mem_wr_en) && $past(wr_eof)); // R5
  AST_LAST_ON_OFFER: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid); // R5
endmodule

bind txring_walker txring_walker_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_last    (tx_last),
  .mem_rd_en  (mem_rd_en),
  .rd_lsb     (mem_rd_addr[1:0]),
  .mem_wr_en  (mem_wr_en),
  .wr_own     (mem_wr_data[31]),
  .wr_eof     (mem_wr_data[29]),
  .frame_done (frame_done)
);

// File: tb/sim_txring_walker.sv
`timescale 1ns/1ps
module sim_txring_walker;
  localparam int AW = 16;
  localparam int MW = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          poll_req = 1'b0;
  logic          base_load = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [31:0]   mem_rd_data = '0;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [31:0]   mem_wr_data;
  logic          tx_valid;
  logic          tx_ready = 1'b1;
  logic [7:0]    tx_data;
  logic          tx_last;
  logic          frame_done;
  logic          seg_err;
  logic          busy;

  always #4 clk = ~clk;

  txring_walker #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .poll_req(poll_req), .base_load(base_load),
    .base_addr(base_addr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .frame_done(frame_done),
    .seg_err(seg_err), .busy(busy)
  );

  logic [31:0] mem [MW];
  logic [31:0] shm [MW];

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[12:2]];
    if (mem_wr_en) mem[mem_wr_addr[12:2]] <= mem_wr_data;
  end

  int checks = 0, bad = 0;
  int exp_frames = 0, got_frames = 0, exp_errs = 0, got_errs = 0;
  logic [8:0]  byte_q [$];
  logic [47:0] wr_q [$];
  logic [15:0] mptr = '0, mbase = '0;
  logic [15:0] last_rd = '0, first_rd = '0, watch = 16'hffff;
  int          watch_cnt = 0;
  bit          first_pend = 0, running = 0, finished = 0;
  int          rdy_mode = 0;
  logic [15:0] lf = 16'hace1;
  bit          prev_hold = 0;
  logic [7:0]  prev_data = '0;
  logic        prev_last = 1'b0;
  logic [8:0]  eb;
  logic [47:0] ew;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdb(input logic [15:0] a);
    logic [31:0] w;
    w = shm[a[12:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic put(input logic [15:0] a, input logic [31:0] v);
    mem[a[12:2]] = v;
    shm[a[12:2]] = v;
  endtask

  task automatic desc(input logic [15:0] a, input logic [31:0] ctl,
                      input int l1, input int l2, input logic [15:0] buf_a);
    put(a, ctl);
    put(a + 16'd4, {4'h0, 12'(l2), 4'h0, 12'(l1)});
    put(a + 16'd8, {16'h0, buf_a});
  endtask

  // Behavioural model of one walk over the shadow memory.
  task automatic model_walk();
    logic [31:0] c, s, a;
    int l1, l2, len;
    while (1) begin
      c = shm[mptr[12:2]];
      if (!c[31]) break;
      s = shm[(mptr + 16'd4) >> 2];
      a = shm[(mptr + 16'd8) >> 2];
      l1 = int'(s[11:0]);
      l2 = int'(s[27:16]);
      if (l1 > 2048 || l2 != 0) exp_errs++;
      len = l1 + l2;
      for (int i = 0; i < len; i++)
        byte_q.push_back({((i == len - 1) && c[29]), rdb(a[15:0] + 16'(i))});
      if (c[29]) exp_frames++;
      wr_q.push_back({mptr, c & 32'h7fff_ffff});
      shm[mptr[12:2]] = c & 32'h7fff_ffff;
      mptr = c[21] ? mbase : mptr + 16'd32;
    end
  endtask

  task automatic pulse_poll();
    @(negedge clk);
    poll_req = 1'b1;
    first_pend = 1;
    @(negedge clk);
    poll_req = 1'b0;
  endtask

  task automatic pulse_base(input logic [15:0] v, input bit update_model);
    @(negedge clk);
    base_addr = v;
    base_load = 1'b1;
    @(negedge clk);
    base_load = 1'b0;
    if (update_model) begin
      mbase = v;
      mptr  = v;
    end
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      q = busy ? 0 : q + 1;
    end
  endtask

  task automatic end_check();
    check(byte_q.size() == 0, "R3", "bytes missing", byte_q.size(), 0);
    check(wr_q.size() == 0, "R6", "write-backs missing", wr_q.size(), 0);
    check(got_frames == exp_frames, "R5", "frame_done count", got_frames, exp_frames);
    check(got_errs == exp_errs, "R8", "seg_err count", got_errs, exp_errs);
    check(last_rd == mptr, "R7", "stop address", last_rd, mptr);
  endtask

  // Monitor: ready is set first, then the handshake due at the next edge is judged.
  always @(negedge clk) begin
    if (rdy_mode == 0) tx_ready = 1'b1;
    else if (rdy_mode == 1) tx_ready = ~tx_ready;
    else begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tx_ready = lf[0] | lf[3];
    end
    if (running) begin
      if (prev_hold)
        check(tx_valid && tx_data == prev_data && tx_last == prev_last,
              "R4", "offer not held", {tx_valid, tx_data}, {1'b1, prev_data});
      if (tx_valid && mem_rd_en)
        check(0, "R4", "read while offering", mem_rd_addr, 0);
      if (tx_valid && tx_ready) begin
        if (byte_q.size() == 0) check(0, "R3", "unexpected byte", tx_data, 0);
        else begin
          eb = byte_q.pop_front();
          check(tx_data == eb[7:0], "R3", "byte value", tx_data, eb[7:0]);
          check(tx_last == eb[8], "R5", "last flag", tx_last, eb[8]);
        end
      end
      if (mem_wr_en) begin
        if (wr_q.size() == 0) check(0, "R6", "unexpected write", mem_wr_addr, 0);
        else begin
          ew = wr_q.pop_front();
          check(mem_wr_addr == ew[47:32], "R6", "write address", mem_wr_addr, ew[47:32]);
          check(mem_wr_data == ew[31:0], "R6", "write data", mem_wr_data, ew[31:0]);
        end
      end
      if (mem_rd_en) begin
        last_rd = mem_rd_addr;
        if (mem_rd_addr == watch) watch_cnt++;
        if (first_pend) begin
          first_rd = mem_rd_addr;
          first_pend = 0;
        end
      end
      if (frame_done) got_frames++;
      if (seg_err) got_errs++;
      prev_hold = tx_valid && !tx_ready;
      prev_data = tx_data;
      prev_last = tx_last;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < MW; w++) begin
      mem[w] = 32'(w) * 32'h9e37_79b1 + 32'h1357_2468;
      shm[w] = mem[w];
    end
    for (int w = 0; w < 128; w++) put(16'(w * 4), 32'h0);

    // R1: reset state
    repeat (3) @(negedge clk);
    check({busy, tx_valid, tx_last, mem_rd_en, mem_wr_en, frame_done, seg_err} == 7'b0,
          "R1", "outputs in reset",
          {busy, tx_valid, tx_last, mem_rd_en, mem_wr_en, frame_done, seg_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    running = 1;
    check({busy, tx_valid, tx_last, mem_rd_en, mem_wr_en, frame_done, seg_err} == 7'b0,
          "R1", "outputs after reset",
          {busy, tx_valid, tx_last, mem_rd_en, mem_wr_en, frame_done, seg_err}, 0);

    // R2 / R10: non-owned descriptor at a freshly loaded base
    pulse_base(16'h0040, 1);
    put(16'h0040, 32'h0000_5555);
    model_walk();
    watch = mptr; watch_cnt = 0;
    pulse_poll();
    wait_idle();
    end_check();
    check(first_rd == 16'h0040, "R10", "first read after base load", first_rd, 16'h0040);
    check(watch_cnt == 1, "R2", "control reads at stop", watch_cnt, 1);

    // R3 R5 R6 R7: three descriptors, unaligned buffer, wrap back to base
    pulse_base(16'h0000, 1);
    desc(16'h0000, 32'h8000_1234, 5, 0, 16'h0401);
    desc(16'h0020, 32'ha000_00f0, 3, 0, 16'h0442);
    desc(16'h0040, 32'ha020_0c00, 4, 0, 16'h0483);
    model_walk();
    pulse_poll();
    wait_idle();
    end_check();

    // R4 R8: random ready, split buffer error, over-size buffer, zero-length end
    rdy_mode = 2;
    pulse_base(16'h0080, 1);
    desc(16'h0080, 32'ha000_0000, 2, 3, 16'h0500);
    desc(16'h00a0, 32'ha000_0000, 2049, 0, 16'h0800);
    desc(16'h00c0, 32'ha020_0000, 0, 0, 16'h0600);
    model_walk();
    pulse_poll();
    wait_idle();
    end_check();

    // R9: poll during a walk restarts at the stop address
    rdy_mode = 1;
    pulse_base(16'h0100, 1);
    desc(16'h0100, 32'ha000_0000, 6, 0, 16'h0602);
    put(16'h0120, 32'h2000_0000);
    model_walk();
    watch = mptr; watch_cnt = 0;
    pulse_poll();
    while (!busy) @(negedge clk);
    repeat (3) @(negedge clk);
    pulse_poll();
    wait_idle();
    end_check();
    check(watch_cnt == 2, "R9", "control reads at stop", watch_cnt, 2);

    // R10 R8: base load while busy ignored; 2048-byte buffer accepted
    rdy_mode = 0;
    pulse_base(16'h0180, 1);
    desc(16'h0180, 32'ha000_0000, 2048, 0, 16'h0800);
    desc(16'h01a0, 32'ha020_0000, 1, 0, 16'h0700);
    model_walk();
    pulse_poll();
    while (!busy) @(negedge clk);
    repeat (20) @(negedge clk);
    pulse_base(16'h0040, 0);
    wait_idle();
    end_check();
    check(last_rd == 16'h0180, "R10", "busy base load ignored", last_rd, 16'h0180);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule